// File: doc/BRIEF.md
# Period-List Playback DMA Sequencer

This block fetches the sample stream for one playback channel. It does not read a single ring buffer. It works through a table of period descriptors held in memory. Software programs three things: the table base address, the byte offset of the last table entry, and a start bit. The sequencer then reads an 8-byte descriptor, which gives the period's buffer address and its length. It issues one word read for each 32-bit sample word in that period, then moves to the next descriptor. After the last entry it returns to entry 0 with no help from software.

The memory side is a plain request/acknowledge port. A request stays up with a stable address until it is acknowledged. Read data comes back in the acknowledge cycle. A flag marks descriptor reads, so that the sample sink can ignore them. Two read-only registers give the playback position: the table offset of the descriptor in use, and the byte offset inside the current period. A status bit is set once for each completed period. It is cleared by writing 1 and is gated by an enable mask onto the interrupt line.

Top module: `period_dma_seq`

## Requirements
- R1: After reset every register reads zero, `mem_req_o` is low and `irq_o` is low.
- R2: Each descriptor is two words, read in this order, both flagged by `mem_is_desc_o`:
  - The word at base+offset holds the buffer address. Its bits [1:0] are ignored.
  - The word at base+offset+4 holds the period length in bytes in bits [31:16]. The period has length/4 words.
- R3: Sample reads go to buffer+4*k for k = 0 .. words-1, in order. Every request holds its address until acknowledged.
- R4: The table-last register (offset 1) holds the offset of the last entry in bits [31:16]. When a period ends at an offset greater than or equal to that value, the next descriptor is at offset 0. Otherwise it is at offset+8.
- R5: Register 2 reads the current descriptor offset in bits [31:16]. Register 3 reads the byte offset of the next sample word in bits [15:0]. Register 3 returns to 0 when a period ends.
- R6: Status bit 0 (register 5) is set in the cycle after the last word of a period is acknowledged. A period with fewer than 4 bytes issues no word reads, completes as soon as its length word is acknowledged, and still sets the bit.
- R7: Writing 1 to status bit 0 clears it. A period completing in the same cycle wins, and the bit stays set.
- R8: `irq_o` is high exactly when status bit 0 and mask bit 0 (register 6) are both set.
- R9: Control bit 0 (register 4) starts channel 0. Setting it while stopped restarts at offset 0 and period position 0. The first descriptor request appears in the second cycle after the write cycle.
- R10: Clearing control bit 0 stops the block once the outstanding request is acknowledged. No further request is issued, and registers 2 and 3 keep their values.
- R11: The register offsets are:

  | Offset | Register |
  |---|---|
  | 0 | table base |
  | 1 | table last |
  | 2 | list position |
  | 3 | period position |
  | 4 | control |
  | 5 | status |
  | 6 | mask |

  Offset 7 and all undefined bits read zero. Control bits [3:1] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory byte address |
| mem_is_desc_o | output | 1 | Current request is a descriptor read |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| irq_o | output | 1 | Period interrupt |

## Verification
A wrong walker state shows on `mem_addr_o` in the very next request, because every address follows from the offset, the buffer and the word count. A lost or extra word count therefore appears as a mismatch in the cycle after the offending acknowledge. A bad offset wrap sends the next descriptor fetch to the wrong table slot within one cycle of the period's end. Status errors show on `irq_o`, and on the readback of register 5, one cycle after the completing acknowledge.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_DESC_ADDR = 2'd1,
    ST_DESC_LEN  = 2'd2,
    ST_STREAM    = 2'd3
  } walk_state_e;

  localparam int unsigned REG_TBL_BASE = 0;
  localparam int unsigned REG_TBL_LAST = 1;
  localparam int unsigned REG_LIST_POS = 2;
  localparam int unsigned REG_PER_POS  = 3;
  localparam int unsigned REG_CTRL     = 4;
  localparam int unsigned REG_STAT     = 5;
  localparam int unsigned REG_MASK     = 6;

  localparam int unsigned DESC_BYTES   = 8;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned REG_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [LEN_W-1:0]  per_pos_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] tbl_base_o,
  output logic [OFS_W-1:0]  tbl_last_o,
  output logic              run_o,
  output logic              stat_o,
  output logic              mask_o
);
  localparam int unsigned HI_PAD = DATA_W - OFS_W;
  localparam int unsigned LO_PAD = DATA_W - LEN_W;

  logic wr_base, wr_last, wr_ctrl, wr_stat, wr_mask;

  assign wr_base = wr_i && (addr_i == REG_AW'(REG_TBL_BASE));
  assign wr_last = wr_i && (addr_i == REG_AW'(REG_TBL_LAST));
  assign wr_ctrl = wr_i && (addr_i == REG_AW'(REG_CTRL));
  assign wr_stat = wr_i && (addr_i == REG_AW'(REG_STAT));
  assign wr_mask = wr_i && (addr_i == REG_AW'(REG_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_base_o <= '0;
      tbl_last_o <= '0;
      run_o      <= 1'b0;
      stat_o     <= 1'b0;
      mask_o     <= 1'b0;
    end else begin
      if (wr_base) tbl_base_o <= ADDR_W'(wdata_i);
      if (wr_last) tbl_last_o <= wdata_i[DATA_W-1 -: OFS_W];
      if (wr_ctrl) run_o      <= wdata_i[0];
      if (wr_mask) mask_o     <= wdata_i[0];
      // completion beats a same-cycle clear
      stat_o <= done_i | (stat_o & ~(wr_stat & wdata_i[0]));
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_AW'(REG_TBL_BASE): rdata_o = DATA_W'(tbl_base_o);
      REG_AW'(REG_TBL_LAST): rdata_o = {tbl_last_o, {HI_PAD{1'b0}}};
      REG_AW'(REG_LIST_POS): rdata_o = {ofs_i, {HI_PAD{1'b0}}};
      REG_AW'(REG_PER_POS):  rdata_o = {{LO_PAD{1'b0}}, per_pos_i};
      REG_AW'(REG_CTRL):     rdata_o = DATA_W'(run_o);
      REG_AW'(REG_STAT):     rdata_o = DATA_W'(stat_o);
      REG_AW'(REG_MASK):     rdata_o = DATA_W'(mask_o);
      default:               rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pdma_walker.sv
module pdma_walker
  import pdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [OFS_W-1:0]  tbl_last_i,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output walk_state_e       state_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [LEN_W-3:0]  wcnt_o,
  output logic [ADDR_W-1:0] buf_o,
  output logic              done_o
);
  localparam int unsigned WCNT_W = LEN_W - 2;

  walk_state_e       state_q;
  logic [OFS_W-1:0]  ofs_q, ofs_next;
  logic [WCNT_W-1:0] wcnt_q, wcnt_inc, lenw_q, len_words;
  logic [ADDR_W-1:0] buf_q;
  logic              last_word, empty_per;

  assign len_words = mem_rdata_i[DATA_W-1 -: WCNT_W];
  assign wcnt_inc  = wcnt_q + WCNT_W'(1);
  assign last_word = (wcnt_inc == lenw_q);
  assign empty_per = (len_words == '0);
  assign ofs_next  = (ofs_q >= tbl_last_i) ? '0 : ofs_q + OFS_W'(DESC_BYTES);

  assign done_o = mem_ack_i &&
                  (((state_q == ST_DESC_LEN) && empty_per) ||
                   ((state_q == ST_STREAM) && last_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ofs_q   <= '0;
      wcnt_q  <= '0;
      lenw_q  <= '0;
      buf_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (run_i) begin
          state_q <= ST_DESC_ADDR;
          ofs_q   <= '0;
          wcnt_q  <= '0;
        end
        ST_DESC_ADDR: if (mem_ack_i) begin
          buf_q   <= ADDR_W'(mem_rdata_i) & ~ADDR_W'(3);
          state_q <= run_i ? ST_DESC_LEN : ST_IDLE;
        end
        ST_DESC_LEN: if (mem_ack_i) begin
          lenw_q <= len_words;
          wcnt_q <= '0;
          if (empty_per) ofs_q <= ofs_next;
          if (!run_i)         state_q <= ST_IDLE;
          else if (empty_per) state_q <= ST_DESC_ADDR;
          else                state_q <= ST_STREAM;
        end
        ST_STREAM: if (mem_ack_i) begin
          if (last_word) begin
            wcnt_q <= '0;
            ofs_q  <= ofs_next;
          end else begin
            wcnt_q <= wcnt_inc;
          end
          if (!run_i)         state_q <= ST_IDLE;
          else if (last_word) state_q <= ST_DESC_ADDR;
          else                state_q <= ST_STREAM;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign ofs_o   = ofs_q;
  assign wcnt_o  = wcnt_q;
  assign buf_o   = buf_q;
endmodule

// File: rtl/pdma_addr.sv
module pdma_addr
  import pdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LEN_W  = 16
) (
  input  walk_state_e       state_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [ADDR_W-1:0] buf_i,
  input  logic [LEN_W-3:0]  wcnt_i,
  output logic              req_o,
  output logic              is_desc_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] entry_addr;

  assign entry_addr = tbl_base_i + ADDR_W'(ofs_i);

  always_comb begin
    req_o     = (state_i != ST_IDLE);
    is_desc_o = (state_i == ST_DESC_ADDR) || (state_i == ST_DESC_LEN);
    unique case (state_i)
      ST_DESC_ADDR: addr_o = entry_addr;
      ST_DESC_LEN:  addr_o = entry_addr + ADDR_W'(4);
      ST_STREAM:    addr_o = buf_i + ADDR_W'({wcnt_i, 2'b00});
      default:      addr_o = '0;
    endcase
  end
endmodule

// File: rtl/period_dma_seq.sv
module period_dma_seq
  import pdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned REG_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_is_desc_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              irq_o
);
  walk_state_e       walk_state;
  logic [OFS_W-1:0]  walk_ofs, tbl_last;
  logic [LEN_W-3:0]  walk_wcnt;
  logic [ADDR_W-1:0] walk_buf, tbl_base;
  logic              walk_done, run, stat, mask;

  pdma_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .LEN_W(LEN_W), .REG_AW(REG_AW)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .ofs_i      (walk_ofs),
    .per_pos_i  ({walk_wcnt, 2'b00}),
    .done_i     (walk_done),
    .tbl_base_o (tbl_base),
    .tbl_last_o (tbl_last),
    .run_o      (run),
    .stat_o     (stat),
    .mask_o     (mask)
  );

  pdma_walker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .LEN_W(LEN_W)
  ) i_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .tbl_last_i  (tbl_last),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .state_o     (walk_state),
    .ofs_o       (walk_ofs),
    .wcnt_o      (walk_wcnt),
    .buf_o       (walk_buf),
    .done_o      (walk_done)
  );

  pdma_addr #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LEN_W(LEN_W)
  ) i_addr (
    .state_i    (walk_state),
    .tbl_base_i (tbl_base),
    .ofs_i      (walk_ofs),
    .buf_i      (walk_buf),
    .wcnt_i     (walk_wcnt),
    .req_o      (mem_req_o),
    .is_desc_o  (mem_is_desc_o),
    .addr_o     (mem_addr_o)
  );

  assign irq_o = stat & mask;
endmodule

// File: rtl/pdma_chk.sv
module pdma_chk
  import pdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_is_desc_o,
  input logic              mem_ack_i,
  input logic              irq_o,
  input walk_state_e       walk_state,
  input logic [OFS_W-1:0]  walk_ofs,
  input logic [OFS_W-1:0]  tbl_last,
  input logic              walk_done,
  input logic              run,
  input logic              stat
);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R6
  done_sets_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_done |=> stat);

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_done && (walk_ofs >= tbl_last)) |=> (walk_ofs == '0));

  // R10
  stopped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((walk_state == ST_IDLE) && !run) |=> !mem_req_o);

  // R2
  desc_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_is_desc_o |-> mem_req_o);

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat);
endmodule

bind period_dma_seq pdma_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_pdma_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_is_desc_o (mem_is_desc_o),
  .mem_ack_i     (mem_ack_i),
  .irq_o         (irq_o),
  .walk_state    (walk_state),
  .walk_ofs      (walk_ofs),
  .tbl_last      (tbl_last),
  .walk_done     (walk_done),
  .run           (run),
  .stat          (stat)
);

// File: tb/test_period_dma_seq.sv
module test_period_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_is_desc, irq;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int wait_cnt = 0;
  int data_acks = 0;
  int desc_acks = 0;
  int head_reads = 0;
  int other_desc = 0;
  logic [31:0] memw [logic [31:0]];

  always #2.5 clk = ~clk;

  period_dma_seq i_period_dma_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_is_desc_o(mem_is_desc),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ms, mofs, mw, mlen, mlast;
  logic [31:0] mbase, mbuf;
  logic        mrun, mstat, mmask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mofs = 0; mw = 0; mlen = 0; mlast = 0;
      mbase = 0; mbuf = 0; mrun = 0; mstat = 0; mmask = 0;
    end else begin
      bit fin;
      int lw;
      fin = 0;
      case (ms)
        0: if (mrun) begin ms = 1; mofs = 0; mw = 0; end
        1: if (mem_ack) begin mbuf = mem_rdata & 32'hFFFF_FFFC; ms = mrun ? 2 : 0; end
        2: if (mem_ack) begin
             lw = int'(mem_rdata >> 18);
             mlen = lw; mw = 0;
             if (lw == 0) begin fin = 1; mofs = (mofs >= mlast) ? 0 : mofs + 8; end
             ms = !mrun ? 0 : (lw == 0 ? 1 : 3);
           end
        default: if (mem_ack) begin
             if (mw + 1 == mlen) begin
               fin = 1; mw = 0; mofs = (mofs >= mlast) ? 0 : mofs + 8;
               ms = mrun ? 1 : 0;
             end else begin
               mw++; ms = mrun ? 3 : 0;
             end
           end
      endcase
      if (reg_wr) begin
        case (reg_addr)
          3'd0: mbase = reg_wdata;
          3'd1: mlast = int'(reg_wdata >> 16);
          3'd4: mrun  = reg_wdata[0];
          3'd5: if (reg_wdata[0]) mstat = 0;
          3'd6: mmask = reg_wdata[0];
          default: ;
        endcase
      end
      if (fin) mstat = 1;
    end
  end

  function automatic logic [31:0] m_addr();
    case (ms)
      1: return mbase + 32'(mofs);
      2: return mbase + 32'(mofs) + 32'd4;
      3: return mbuf + 32'(mw * 4);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return mbase;
      3'd1: return 32'(mlast) << 16;
      3'd2: return 32'(mofs) << 16;
      3'd3: return 32'(mw * 4);
      3'd4: return {31'd0, mrun};
      3'd5: return {31'd0, mstat};
      3'd6: return {31'd0, mmask};
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R3 request", {31'd0, mem_req}, {31'd0, ms != 0});
      if (mem_req) chk("R3 address", mem_addr, m_addr());
      chk("R2 descriptor flag", {31'd0, mem_is_desc}, {31'd0, ms == 1 || ms == 2});
      chk("R8 irq", {31'd0, irq}, {31'd0, mstat & mmask});
      chk("R5 readback", reg_rdata, m_rd(reg_addr));
    end
  end

  // memory responder: variable latency, one-cycle acknowledge
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (memw.exists(a)) return memw[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req && wait_cnt == 0) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem_word(mem_addr);
      wait_cnt  <= $urandom_range(0, 2);
      if (mem_is_desc) begin
        desc_acks++;
        if (mem_addr == 32'h1000) head_reads++;
        if (mem_addr != 32'h1000 && mem_addr != 32'h1004 &&
            mem_addr != 32'h1008 && mem_addr != 32'h100C &&
            mem_addr != 32'h1010 && mem_addr != 32'h1014) other_desc++;
      end else begin
        data_acks++;
      end
    end else if (mem_req) begin
      wait_cnt <= wait_cnt - 1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int snap_d, snap_a;
    // table: 16-byte period, 8-byte period, empty period
    memw[32'h1000] = 32'h0000_2001; memw[32'h1004] = 32'h0010_0000;
    memw[32'h1008] = 32'h0000_3000; memw[32'h100C] = 32'h0008_0000;
    memw[32'h1010] = 32'h0000_4000; memw[32'h1014] = 32'h0000_0000;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, "R1 register reset value");
    chk("R1 request after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0010_0000);
    wr(3'd6, 32'd1);
    wr(3'd4, 32'd1);
    #1;
    chk("R9 no request yet", {31'd0, mem_req}, 32'd0);
    @(negedge clk); #1;
    chk("R9 first request", {31'd0, mem_req}, 32'd1);
    chk("R9 first address at entry 0", mem_addr, 32'h0000_1000);
    chk("R2 first request is descriptor", {31'd0, mem_is_desc}, 32'd1);

    for (int i = 0; i < 300 && !irq; i++) @(negedge clk);
    chk("R6 words in first period", 32'(data_acks), 32'd4);
    rd(3'd3, 32'd0, "R5 period position after period end");
    rd(3'd2, 32'h0008_0000, "R5 list position at entry 1");
    rd(3'd5, 32'd1, "R6 status set");

    wr(3'd5, 32'd1);
    rd(3'd5, 32'd0, "R7 status cleared by write 1");
    chk("R7 irq low after clear", {31'd0, irq}, 32'd0);

    wr(3'd6, 32'd0);
    for (int i = 0; i < 300 && !mstat; i++) @(negedge clk);
    rd(3'd5, 32'd1, "R8 status set with mask off");
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'd1);
    #1;
    chk("R8 irq after unmask", {31'd0, irq}, 32'd1);

    for (int i = 0; i < 600 && head_reads < 2; i++) @(negedge clk);
    chk("R4 wrapped to entry 0", 32'(head_reads), 32'd2);
    chk("R6 empty period issued no words", 32'(data_acks), 32'd6);
    chk("R4 no descriptor outside table", 32'(other_desc), 32'd0);

    repeat (200) @(negedge clk);
    wr(3'd4, 32'd0);
    repeat (10) @(negedge clk);
    snap_d = data_acks; snap_a = desc_acks;
    chk("R10 request low after stop", {31'd0, mem_req}, 32'd0);
    repeat (30) @(negedge clk);
    chk("R10 no traffic while stopped", 32'(data_acks + desc_acks), 32'(snap_d + snap_a));
    rd(3'd2, m_rd(3'd2), "R10 list position held");
    rd(3'd3, m_rd(3'd3), "R10 period position held");

    wr(3'd4, 32'hFFFF_FFFE);
    rd(3'd4, 32'd0, "R11 control upper bits ignored");
    repeat (5) @(negedge clk);
    chk("R11 no start from bits 3:1", {31'd0, mem_req}, 32'd0);
    rd(3'd7, 32'd0, "R11 offset 7 reads zero");
    wr(3'd1, 32'h0000_ABCD);
    rd(3'd1, 32'd0, "R11 table-last low bits read zero");

    // single-entry table: every period wraps
    snap_a = other_desc;
    wr(3'd4, 32'd1);
    #1;
    chk("R9 restart no request yet", {31'd0, mem_req}, 32'd0);
    @(negedge clk); #1;
    chk("R9 restart at entry 0", mem_addr, 32'h0000_1000);
    rd(3'd2, 32'd0, "R9 list position reset");
    head_reads = 0;
    for (int i = 0; i < 600 && head_reads < 4; i++) @(negedge clk);
    chk("R4 single entry repeats", 32'(head_reads), 32'd4);
    chk("R4 single entry stays in slot 0", 32'(other_desc), 32'(snap_a));
    rd(3'd2, 32'd0, "R4 list position stays 0");

    repeat (20) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule